// File: doc/BRIEF.md
# Debug-Mode Exception Re-Entry Unit

This block handles an exception raised while the processor is already in debug mode. On such an exception it captures a return address, records whether that address belongs to a branch whose delay slot faulted, and stores the exception cause. It also clears the debug-cause flags, sets the imprecise-exception inhibit flag and redirects fetch to one of two debug vectors. The debug-mode flag itself stays untouched, so the handler runs again at the vector while still in debug mode.

The block owns the debug status word and the return-PC register. Other logic updates the status word through a plain load port. The block also produces the qualifier that lets interrupt exceptions through only outside debug mode and only when the debug control interrupt-enable bit is set.

Top module: `dbgReentryTop`

## Requirements
- R1: An entry happens only in a cycle where `excValid` and `debugMode` are both 1. With `excValid` high and `debugMode` low, `redirect` stays 0 and neither `statusWord` nor `returnPc` changes.
- R2: On an entry with `inDelaySlot`=1, `returnPc` takes `branchPc` and status bit 16 (delay-slot flag) becomes 1.
- R3: On an entry with `inDelaySlot`=0, `returnPc` takes `curPc` and status bit 16 becomes 0.
- R4: On an entry, status bits 7:0 (the eight debug-cause flags) all become 0.
- R5: On an entry, status bits 15:11 take `excCode`, and every 5-bit value is stored as given, including 30 (cache error).
- R6: On an entry, status bit 10 (imprecise-exception inhibit) becomes 1.
- R7: An entry leaves status bits 9:8 (halt and doze) and bits 31:17 at their previous values.
- R8: In the cycle of an entry, `redirect` is 1 and `newPc` is 0xFF200200 when `probeTrap` is 1, or 0xBFC00480 when it is 0. Outside an entry `redirect` is 0.
- R9: `intAllow` is 1 exactly when `debugMode` is 0 and `intEnable` is 1.
- R10: After reset, `statusWord` and `returnPc` are 0.
- R11: When `loadEn` is 1 and no entry happens, `statusWord` takes `loadData` on the next edge. An entry in the same cycle takes priority, and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| excValid | input | 1 | Exception strobe |
| excCode | input | 5 | Exception type code |
| curPc | input | 32 | PC of the faulting instruction |
| inDelaySlot | input | 1 | Faulting instruction sits in a branch delay slot |
| branchPc | input | 32 | PC of the branch that owns the delay slot |
| probeTrap | input | 1 | Selects the probe-side debug vector |
| debugMode | input | 1 | Processor is in debug mode |
| intEnable | input | 1 | Interrupt-enable bit of the debug control register |
| loadEn | input | 1 | Load strobe for the status word |
| loadData | input | 32 | Value for the status word load |
| statusWord | output | 32 | Debug status word |
| returnPc | output | 32 | Captured return address |
| redirect | output | 1 | Fetch redirect strobe |
| newPc | output | 32 | Redirect target |
| intAllow | output | 1 | Interrupt exceptions permitted |

## Verification
The bench first loads the status word with all ones and then with patterns that mix ones and zeros. A following entry must then visibly clear the cause flags while keeping the halt/doze bits and the upper bits, which tells a masked update apart from a full overwrite. Entries are run from a delay slot and from a plain slot, using different PCs and branch PCs, so that a swapped address source is caught. Both vector selections and several cause codes, including 30 and 0, are also covered. Exceptions arriving outside debug mode, and a load coinciding with an entry, show whether the gating and the priority hold. All four combinations of the interrupt inputs are driven.

// File: rtl/dbgReentryPkg.sv
package dbgReentryPkg;
  typedef struct packed {
    logic enter;
    logic fromSlot;
    logic useProbe;
    logic load;
  } dbgStrobe_t;

  localparam int CAUSE_FLAGS = 8;
  localparam int HALT_POS    = 8;
  localparam int DOZE_POS    = 9;
  localparam int INHIBIT_POS = 10;
  localparam int CODE_LO     = 11;
endpackage

// File: rtl/dbgReentryCtrl.sv
module dbgReentryCtrl
  import dbgReentryPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       excValid,
  input  logic       debugMode,
  input  logic       inDelaySlot,
  input  logic       probeTrap,
  input  logic       loadEn,
  input  logic       intEnable,
  output dbgStrobe_t stb,
  output logic       redirect,
  output logic       intAllow
);
  logic enterNow;

  always_comb begin
    enterNow     = excValid & debugMode;
    stb.enter    = enterNow;
    stb.fromSlot = enterNow & inDelaySlot;
    stb.useProbe = probeTrap;
    stb.load     = loadEn & ~enterNow;
    redirect     = enterNow;
    intAllow     = ~debugMode & intEnable;
  end

  // R11
  load_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |-> !stb.load);

  // R9
  int_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> !intAllow);
endmodule

// File: rtl/dbgReentryDpath.sv
module dbgReentryDpath
  import dbgReentryPkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          CODE_W    = 5,
  parameter int          REG_W     = 32,
  parameter logic [31:0] VEC_PROBE = 32'hFF20_0200,
  parameter logic [31:0] VEC_NORM  = 32'hBFC0_0480
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbgStrobe_t        stb,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] branchPc,
  input  logic [REG_W-1:0]  loadData,
  output logic [REG_W-1:0]  statusWord,
  output logic [ADDR_W-1:0] returnPc,
  output logic [ADDR_W-1:0] newPc
);
  localparam int CODE_HI  = CODE_LO + CODE_W - 1;
  localparam int SLOT_POS = CODE_HI + 1;

  logic [REG_W-1:0]  statusQ, statusNext;
  logic [ADDR_W-1:0] retQ, retNext;

  always_comb begin
    statusNext = statusQ;
    retNext    = retQ;
    if (stb.enter) begin
      statusNext[CAUSE_FLAGS-1:0]  = '0;
      statusNext[INHIBIT_POS]      = 1'b1;
      statusNext[CODE_HI:CODE_LO]  = excCode;
      statusNext[SLOT_POS]         = stb.fromSlot;
      retNext = stb.fromSlot ? branchPc : curPc;
    end else if (stb.load) begin
      statusNext = loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      retQ    <= '0;
    end else begin
      statusQ <= statusNext;
      retQ    <= retNext;
    end
  end

  assign newPc      = stb.useProbe ? VEC_PROBE[ADDR_W-1:0] : VEC_NORM[ADDR_W-1:0];
  assign statusWord = statusQ;
  assign returnPc   = retQ;

  // R4
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |=> statusWord[CAUSE_FLAGS-1:0] == '0);

  // R6
  inhibit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |=> statusWord[INHIBIT_POS]);

  // R7
  halt_doze_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |=> statusWord[DOZE_POS:HALT_POS] == $past(statusWord[DOZE_POS:HALT_POS]));

  // R1
  ret_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.enter |=> $stable(returnPc));

  // R5
  code_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.enter |=> statusWord[CODE_HI:CODE_LO] == $past(excCode));
endmodule

// File: rtl/dbgReentryTop.sv
module dbgReentryTop
  import dbgReentryPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 5,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              inDelaySlot,
  input  logic [ADDR_W-1:0] branchPc,
  input  logic              probeTrap,
  input  logic              debugMode,
  input  logic              intEnable,
  input  logic              loadEn,
  input  logic [REG_W-1:0]  loadData,
  output logic [REG_W-1:0]  statusWord,
  output logic [ADDR_W-1:0] returnPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] newPc,
  output logic              intAllow
);
  dbgStrobe_t stb;

  dbgReentryCtrl uCtrl (
    .clk(clk), .rstN(rstN), .excValid(excValid), .debugMode(debugMode),
    .inDelaySlot(inDelaySlot), .probeTrap(probeTrap), .loadEn(loadEn),
    .intEnable(intEnable), .stb(stb), .redirect(redirect), .intAllow(intAllow)
  );

  dbgReentryDpath #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .REG_W(REG_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .excCode(excCode), .curPc(curPc),
    .branchPc(branchPc), .loadData(loadData), .statusWord(statusWord),
    .returnPc(returnPc), .newPc(newPc)
  );
endmodule

// File: tb/dbgReentryTop_test.sv
module dbgReentryTop_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [4:0]  excCode = '0;
  logic [31:0] curPc = '0;
  logic        inDelaySlot = 1'b0;
  logic [31:0] branchPc = '0;
  logic        probeTrap = 1'b0;
  logic        debugMode = 1'b0;
  logic        intEnable = 1'b0;
  logic        loadEn = 1'b0;
  logic [31:0] loadData = '0;
  logic [31:0] statusWord, returnPc, newPc;
  logic        redirect, intAllow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [31:0] st; logic [31:0] rp; string tag; } expItem_t;
  expItem_t sb[$];
  logic [31:0] mSt = '0, mRp = '0;

  always #4 clk = ~clk;

  dbgReentryTop uut (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode), .curPc(curPc),
    .inDelaySlot(inDelaySlot), .branchPc(branchPc), .probeTrap(probeTrap),
    .debugMode(debugMode), .intEnable(intEnable), .loadEn(loadEn), .loadData(loadData),
    .statusWord(statusWord), .returnPc(returnPc), .redirect(redirect), .newPc(newPc),
    .intAllow(intAllow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; comb outputs checked now, state pushed for the monitor
  task automatic drive(input string tag, input bit ex, input bit dm, input bit slot,
                       input logic [4:0] code, input logic [31:0] pc, input logic [31:0] bpc,
                       input bit pt, input bit ld, input logic [31:0] ldd);
    expItem_t it;
    bit enter;
    @(negedge clk);
    excValid = ex; debugMode = dm; inDelaySlot = slot; excCode = code;
    curPc = pc; branchPc = bpc; probeTrap = pt; loadEn = ld; loadData = ldd;
    #1;
    enter = ex && dm;
    chk({tag, " R8 redirect"}, {31'b0, redirect}, {31'b0, enter});
    if (enter)
      chk({tag, " R8 vector"}, newPc, pt ? 32'hFF20_0200 : 32'hBFC0_0480);
    if (enter) begin
      mSt = {mSt[31:17], slot, code, 1'b1, mSt[9:8], 8'h00};
      mRp = slot ? bpc : pc;
    end else if (ld) begin
      mSt = ldd;
    end
    it.st = mSt; it.rp = mRp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: results appear after the posedge between two negedges
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      chk({it.tag, " status"}, statusWord, it.st);
      chk({it.tag, " retpc"}, returnPc, it.rp);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    // R10 reset state
    chk("R10 status reset", statusWord, 32'h0);
    chk("R10 retpc reset", returnPc, 32'h0);
    #20 rstN = 1'b1;

    // R11 load all ones
    drive("R11 load", 0, 1, 0, 5'd0, 32'h0, 32'h0, 0, 1, 32'hFFFF_FFFF);
    // R3 R4 R6 R7 plain slot, probe 0
    drive("R3 plain entry", 1, 1, 0, 5'd5, 32'h8000_1234, 32'h8000_1230, 0, 0, 32'h0);
    // R2 R5 delay slot, cache error 30, probe 1
    drive("R2 slot entry", 1, 1, 1, 5'd30, 32'h8000_2004, 32'h8000_2000, 1, 0, 32'h0);
    // R1 outside debug mode ignored
    drive("R1 no-debug", 1, 0, 1, 5'd7, 32'h1111_1111, 32'h2222_2222, 1, 0, 32'h0);
    // R11 load mixed pattern, then entry keeps halt/doze and upper bits (R7)
    drive("R11 load mix", 0, 1, 0, 5'd0, 32'h0, 32'h0, 0, 1, 32'hA5A5_02FF);
    drive("R7 keep", 1, 1, 0, 5'd0, 32'hBFC0_0000, 32'h0, 0, 0, 32'h0);
    drive("R11 load other", 0, 1, 0, 5'd0, 32'h0, 32'h0, 0, 1, 32'h5A5A_01C3);
    // R11 entry wins over simultaneous load
    drive("R11 prio", 1, 1, 1, 5'd31, 32'h3333_0000, 32'h4444_0000, 1, 1, 32'h0000_0000);
    drive("R1 idle", 0, 1, 0, 5'd9, 32'h5555_5555, 32'h6666_6666, 0, 0, 32'h0);
    drive("R5 code", 1, 1, 0, 5'd12, 32'h0000_0040, 32'h0, 1, 0, 32'h0);
    drive("R1 idle end", 0, 0, 0, 5'd0, 32'h0, 32'h0, 0, 0, 32'h0);

    // R9 interrupt qualifier, all combinations
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      debugMode = i[0]; intEnable = i[1];
      #1;
      chk("R9 intAllow", {31'b0, intAllow}, {31'b0, (!i[0] && i[1])});
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule